// File: doc/BRIEF.md
# Four-Channel Phase-Stepped Clock Divider

This block is the digital model of four clock output channels fed from one oscillator. It runs on a step clock at eight ticks per oscillator period, so a single tick equals the smallest phase step of one eighth of that period. Each channel divides by its own ratio of 1 to 63 oscillator periods. It produces an output that is high for exactly half of its period, odd ratios included. Each channel can also delay its output by a phase offset counted in ticks.

The offset of a dynamic channel moves by one tick for each pulse on that channel's bit of `phase_inc_i`. The move takes effect only at the end of the channel's current period, so the output never shows a shortened pulse. The offset wraps modulo the period length and reports each wrap with a one-cycle flag. A channel built with its static enable set keeps a fixed offset taken from a parameter. A shared active-low phase-reset input brings every dynamic offset back to zero in the same cycle.

Top module: `prd_quad_phase_div`

## Requirements
- R1: While `rst_ni` is low, every `clk_o` and `wrap_o` bit is 0. After release, every dynamic channel has offset zero, so channels with equal ratios rise in the same step-clock cycle.
- R2: A channel with ratio N (field `ratio_i[c*6 +: 6]`) has a period of 8N ticks, with `clk_o[c]` high for 4N ticks and low for 4N ticks, for every N from 1 to 63, odd N included.
- R3: A ratio field of 0 acts as ratio 1, giving 4 ticks high and 4 ticks low.
- R4: The ratio is sampled at the last tick of each period, and the first period after reset is 8 ticks. When the sampled ratio differs from the current one, the dynamic offset is cleared to zero and any pending increment is dropped.
- R5: A one-cycle pulse on `phase_inc_i[c]` makes `clk_o[c]` rise one tick later than before, relative to an unshifted channel of the same ratio. The change is applied at the end of the channel's current period.
- R6: Extra pulses on a channel that arrive while an earlier increment of that channel is still waiting for the period end are merged into it and add no further step.
- R7: The offset wraps from 8N-1 back to 0. On each wrap, `wrap_o[c]` is high for exactly one cycle.
- R8: A low level on `outph_rst_ni` sets the offset of every dynamic channel to zero and clears their pending increments, all in the same cycle.
- R9: A channel whose `STATIC_EN` bit is 1 keeps the offset `STATIC_PHASE[c*3 +: 3]` (0 to 7 ticks) at all times. Its `phase_inc_i` bit and `outph_rst_ni` have no effect on it, and its `wrap_o` bit stays 0.
- R10: Increments, wraps and offsets of one channel leave the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock, eight ticks per oscillator period |
| rst_ni | input | 1 | Asynchronous active-low reset of the whole block |
| outph_rst_ni | input | 1 | Synchronous active-low clear of all dynamic phase offsets |
| ratio_i | input | 24 | Per-channel division ratio, 6 bits per channel, channel c at bits c*6 +: 6 |
| phase_inc_i | input | 4 | Per-channel one-tick phase advance request |
| clk_o | output | 4 | Divided, phase-shifted clock outputs |
| wrap_o | output | 4 | One-cycle pulse when a channel's offset wraps to zero |

## Verification
The bench measures high and low run lengths at ratios 1, 5, 63 and 0. A divider that rounded odd ratios, or let a zero ratio through, would show runs of the wrong length. Phase is measured as the lag between a shifted channel's rising edge and the edge of an unshifted reference channel. That catches an increment counted twice when two pulses fall inside one period, a wrap that goes to the wrong value or never raises its flag, and a phase reset that misses a channel or reaches the static one. A final change of ratio on all channels together confirms that a nonzero offset is dropped when the period changes.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int unsigned TICKS_PER_VCO = 8;

  // ratio code 0 is not a legal division; run it as 1
  function automatic int unsigned norm_ratio(input int unsigned r);
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/prd_div_counter.sv
module prd_div_counter
  import prd_pkg::*;
#(
  parameter int unsigned RATIO_W = 6,
  parameter int unsigned STEPS   = TICKS_PER_VCO,
  parameter int unsigned CNT_W   = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   per_o,
  output logic [CNT_W-1:0]   half_o,
  output logic               bnd_o,
  output logic               rchg_o
);

  localparam int unsigned STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CNT_W-1:0] cnt_q, per_q, per_nx;

  assign per_nx = CNT_W'(STEPS * norm_ratio(32'(ratio_i)));
  assign bnd_o  = (cnt_q == per_q - CNT_W'(1));
  assign rchg_o = bnd_o && (per_nx != per_q);
  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign half_o = per_q >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= CNT_W'(STEPS);
    end else if (bnd_o) begin
      cnt_q <= '0;
      per_q <= per_nx;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2: tick counter stays inside the current period
  a_r2_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);

  // R3: period is always a nonzero whole number of oscillator periods
  a_r3_period_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0) && (per_q[STEP_W-1:0] == '0));

endmodule

// File: rtl/prd_phase_offset.sv
module prd_phase_offset #(
  parameter int unsigned CNT_W      = 9,
  parameter bit          STATIC_EN  = 1'b0,
  parameter int unsigned STATIC_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             outph_rst_ni,
  input  logic             inc_i,
  input  logic             bnd_i,
  input  logic             rchg_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] off_o,
  output logic             wrap_o
);

  if (STATIC_EN) begin : g_static
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, outph_rst_ni, inc_i, bnd_i, rchg_i, per_i};
    assign off_o  = CNT_W'(STATIC_VAL);
    assign wrap_o = 1'b0;
  end else begin : g_dynamic
    logic [CNT_W-1:0] off_q, off_inc;
    logic             pend_q, wrap_q, hit;

    assign off_inc = off_q + CNT_W'(1);
    assign hit     = (off_inc == per_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q  <= '0;
        pend_q <= 1'b0;
        wrap_q <= 1'b0;
      end else if (!outph_rst_ni) begin
        off_q  <= '0;
        pend_q <= 1'b0;
        wrap_q <= 1'b0;
      end else begin
        wrap_q <= 1'b0;
        if (bnd_i && rchg_i) begin
          off_q  <= '0;
          pend_q <= inc_i;
        end else if (bnd_i && pend_q) begin
          off_q  <= hit ? '0 : off_inc;
          wrap_q <= hit;
          pend_q <= inc_i;
        end else if (inc_i) begin
          pend_q <= 1'b1;
        end
      end
    end

    assign off_o  = off_q;
    assign wrap_o = wrap_q;

    // R7: offset stays below the active period
    a_r7_off_below_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_q < per_i);

    // R7: wrap flag never lasts two cycles
    a_r7_wrap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_q |=> !wrap_q);

    // R5: offset moves only at a period end or on phase reset
    a_r5_off_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(off_q) |-> $past(bnd_i || !outph_rst_ni));

    // R6: a pending step is held until the period end
    a_r6_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !bnd_i && outph_rst_ni) |=> pend_q);

    // R8: phase reset clears offset and pending step
    a_r8_outph_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !outph_rst_ni |=> (off_q == '0) && !pend_q);
  end

endmodule

// File: rtl/prd_phase_out.sv
module prd_phase_out #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             clk_o
);

  logic [CNT_W-1:0] pos;
  logic             clk_q;

  // position inside the period after the delay, modulo the period
  always_comb begin
    if (cnt_i >= off_i) pos = cnt_i - off_i;
    else                pos = cnt_i + per_i - off_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else         clk_q <= (pos < half_i);
  end

  assign clk_o = clk_q;

  // R2: delayed position never leaves the period
  a_r2_pos_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos < per_i);

endmodule

// File: rtl/prd_channel.sv
module prd_channel #(
  parameter int unsigned RATIO_W    = 6,
  parameter int unsigned STEPS      = 8,
  parameter int unsigned CNT_W      = 9,
  parameter bit          STATIC_EN  = 1'b0,
  parameter int unsigned STATIC_VAL = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               outph_rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               inc_i,
  output logic               clk_o,
  output logic               wrap_o
);

  logic [CNT_W-1:0] cnt, per, half, off;
  logic             bnd, rchg;

  prd_div_counter #(.RATIO_W(RATIO_W), .STEPS(STEPS), .CNT_W(CNT_W)) u_div (
    .clk_i, .rst_ni, .ratio_i,
    .cnt_o(cnt), .per_o(per), .half_o(half), .bnd_o(bnd), .rchg_o(rchg)
  );

  prd_phase_offset #(.CNT_W(CNT_W), .STATIC_EN(STATIC_EN), .STATIC_VAL(STATIC_VAL)) u_off (
    .clk_i, .rst_ni, .outph_rst_ni, .inc_i,
    .bnd_i(bnd), .rchg_i(rchg), .per_i(per), .off_o(off), .wrap_o
  );

  prd_phase_out #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .cnt_i(cnt), .per_i(per), .half_i(half), .off_i(off), .clk_o
  );

endmodule

// File: rtl/prd_quad_phase_div.sv
module prd_quad_phase_div
  import prd_pkg::*;
#(
  parameter int unsigned           NCH          = 4,
  parameter int unsigned           RATIO_W      = 6,
  parameter int unsigned           STEPS        = TICKS_PER_VCO,
  parameter logic [NCH-1:0]        STATIC_EN    = '0,
  parameter logic [NCH*$clog2(STEPS)-1:0] STATIC_PHASE = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   outph_rst_ni,
  input  logic [NCH*RATIO_W-1:0] ratio_i,
  input  logic [NCH-1:0]         phase_inc_i,
  output logic [NCH-1:0]         clk_o,
  output logic [NCH-1:0]         wrap_o
);

  localparam int unsigned MAX_RATIO = (1 << RATIO_W) - 1;
  localparam int unsigned MAX_PER   = STEPS * MAX_RATIO;
  localparam int unsigned CNT_W     = $clog2(MAX_PER + 1);
  localparam int unsigned STEP_W    = $clog2(STEPS);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    prd_channel #(
      .RATIO_W   (RATIO_W),
      .STEPS     (STEPS),
      .CNT_W     (CNT_W),
      .STATIC_EN (STATIC_EN[c]),
      .STATIC_VAL(int'(STATIC_PHASE[c*STEP_W +: STEP_W]))
    ) u_ch (
      .clk_i,
      .rst_ni,
      .outph_rst_ni,
      .ratio_i(ratio_i[c*RATIO_W +: RATIO_W]),
      .inc_i  (phase_inc_i[c]),
      .clk_o  (clk_o[c]),
      .wrap_o (wrap_o[c])
    );
  end

endmodule

// File: tb/prd_quad_phase_div_tb_top.sv
module prd_quad_phase_div_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, outph_n;
  logic [23:0] ratio;
  logic [3:0]  inc;
  logic [3:0]  clk_o, wrap_o;

  always #5 clk = ~clk;

  prd_quad_phase_div #(
    .STATIC_EN   (4'b1000),
    .STATIC_PHASE(12'hA00)   // channel 3 fixed at 5 ticks
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .outph_rst_ni(outph_n),
    .ratio_i(ratio), .phase_inc_i(inc), .clk_o(clk_o), .wrap_o(wrap_o)
  );

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int wrap_cnt [4] = '{0, 0, 0, 0};
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n === 1'b1)
      for (int c = 0; c < 4; c++) wrap_cnt[c] += int'(wrap_o[c]);

  localparam int K_LAG = 0, K_HI = 1, K_LO = 2, K_WRAP = 3;
  typedef struct { int ch; int kind; int val; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic compare(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push(input int ch, input int kind, input int val, input string tag);
    exp_t e;
    e.ch = ch; e.kind = kind; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic measure_lag(input int ch, output int lag);
    logic [3:0] prev, cur, rise;
    bit seen0;
    int t0;
    lag = -1; seen0 = 1'b0; t0 = 0; prev = clk_o;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cur = clk_o; rise = cur & ~prev; prev = cur;
      if (!seen0 && rise[0]) begin seen0 = 1'b1; t0 = cyc; end
      if (seen0 && rise[ch]) begin lag = cyc - t0; return; end
    end
  endtask

  task automatic measure_width(input int ch, input bit want_hi, output int w);
    logic p;
    bit found;
    int hi, lo;
    w = -1; found = 1'b0; p = clk_o[ch];
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk);
      if (!p && clk_o[ch]) found = 1'b1;
      p = clk_o[ch];
    end
    if (!found) return;
    hi = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (clk_o[ch]) hi++; else break;
    end
    lo = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!clk_o[ch]) lo++; else break;
    end
    w = want_hi ? hi : lo;
  endtask

  // monitor: pop each expected item and measure it
  task automatic drain();
    exp_t e;
    int got;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      case (e.kind)
        K_LAG:   measure_lag(e.ch, got);
        K_HI:    measure_width(e.ch, 1'b1, got);
        K_LO:    measure_width(e.ch, 1'b0, got);
        default: got = wrap_cnt[e.ch];
      endcase
      compare($sformatf("%s ch%0d kind%0d", e.tag, e.ch, e.kind), got, e.val);
    end
  endtask

  task automatic set_ratio(input int ch, input int val);
    ratio[ch*6 +: 6] = 6'(val);
  endtask

  task automatic block_reset(input int r);
    @(negedge clk);
    rst_n = 1'b0;
    for (int c = 0; c < 4; c++) set_ratio(c, r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int ch, input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); inc[ch] = 1'b1;
      @(negedge clk); inc[ch] = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic sync_rise0();
    int dummy;
    measure_lag(0, dummy);
  endtask

  initial begin
    int unsigned lim = 200000;
    repeat (lim) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; outph_n = 1'b1; inc = '0; ratio = '0;
    set_ratio(0, 1); set_ratio(1, 5); set_ratio(2, 63); set_ratio(3, 0);
    repeat (3) @(negedge clk);
    compare("R1 clk_o in reset", int'(clk_o), 0);
    compare("R1 wrap_o in reset", int'(wrap_o), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    push(0, K_HI, 4, "R2 ratio1"); push(0, K_LO, 4, "R2 ratio1");
    push(1, K_HI, 20, "R2 odd ratio5"); push(1, K_LO, 20, "R2 odd ratio5");
    push(2, K_HI, 252, "R2 ratio63"); push(2, K_LO, 252, "R2 ratio63");
    push(3, K_HI, 4, "R3 ratio0"); push(3, K_LO, 4, "R3 ratio0");
    drain();

    // aligned channels, ratio 3 (24 ticks)
    block_reset(3);
    repeat (40) @(negedge clk);
    push(1, K_LAG, 0, "R1 aligned"); push(2, K_LAG, 0, "R1 aligned");
    push(3, K_LAG, 5, "R9 static offset");
    drain();

    // ch1 one pulse; ch2 two pulses in one period; ch3 pulse ignored
    sync_rise0();
    @(negedge clk); inc = 4'b0110;
    @(negedge clk); inc = 4'b0000;
    @(negedge clk); inc = 4'b1100;
    @(negedge clk); inc = 4'b0000;
    repeat (60) @(negedge clk);
    push(1, K_LAG, 1, "R5 one step"); push(2, K_LAG, 1, "R6 merged pulses");
    push(3, K_LAG, 5, "R9 inc ignored");
    drain();

    pulse(1, 3, 30);
    repeat (40) @(negedge clk);
    push(1, K_LAG, 4, "R5 four steps"); push(2, K_LAG, 1, "R10 ch2 untouched");
    drain();

    pulse(1, 20, 30);
    repeat (40) @(negedge clk);
    push(1, K_LAG, 0, "R7 wrapped offset"); push(1, K_WRAP, 1, "R7 one wrap pulse");
    push(2, K_WRAP, 0, "R10 no wrap on ch2"); push(3, K_WRAP, 0, "R9 no wrap static");
    drain();

    pulse(2, 2, 30);
    repeat (40) @(negedge clk);
    push(2, K_LAG, 3, "R10 ch2 steps"); push(1, K_LAG, 0, "R10 ch1 unchanged");
    drain();

    @(negedge clk); outph_n = 1'b0;
    @(negedge clk); outph_n = 1'b1;
    repeat (60) @(negedge clk);
    push(2, K_LAG, 0, "R8 phase reset"); push(3, K_LAG, 5, "R9 phase reset ignored");
    drain();

    pulse(1, 2, 30);
    repeat (40) @(negedge clk);
    push(1, K_LAG, 2, "R5 two steps");
    drain();

    for (int c = 0; c < 4; c++) set_ratio(c, 2);
    repeat (80) @(negedge clk);
    push(1, K_LAG, 0, "R4 ratio change clears"); push(3, K_LAG, 5, "R9 static after change");
    push(1, K_HI, 8, "R4 new ratio"); push(1, K_LO, 8, "R4 new ratio");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule